// File: doc/BRIEF.md
# Two-Stage Pair/Group Input Selector

This block chooses which of eight candidate routing signals feeds one input of a logic cell. The candidates form two groups of four: a high group (A, B, C, D) and a low group (E, F, G, H). Pair k joins the k-th member of each group, so pair 0 is A/E, pair 1 is B/F, pair 2 is C/G and pair 3 is D/H. A 5-bit configuration code drives the selection, and no binary decoder sits in the path. Four one-hot pair enables pick a pair in the first stage. One group bit then picks the high or the low member of that pair in the second stage.

A cell input may be driven by no more than one candidate. If no pair enable is set, the input is unused and the output is a steady 0. If two or more pair enables are set, the code is illegal: the block forces the output to 0 and raises an error flag, so the conflicting candidates are never merged. The pair count and the candidate width are parameters. A generate option chooses between a registered output, which is the default, and a purely combinational one.

Top module: `isel_two_stage`

## Requirements
- R1: Candidate k of the high group sits at `cand_hi[k*DATA_W +: DATA_W]`, and candidate k of the low group sits at `cand_lo[k*DATA_W +: DATA_W]`. Pair k is made of those two candidates and is enabled by `sel_cfg[k]`.
- R2: When exactly one pair enable `sel_cfg[k]` is set and the group bit `sel_cfg[PAIRS]` is 1, the output equals high candidate k.
- R3: When exactly one pair enable `sel_cfg[k]` is set and the group bit is 0, the output equals low candidate k.
- R4: The code `5'b1_0010`, with pair 1 enabled and the high group chosen, passes candidate B (`cand_hi[1]`) and nothing else.
- R5: When all pair enables are 0, the output is 0 and `cfg_err` is 0, whatever the candidates carry.
- R6: When two or more pair enables are set, `cfg_err` is 1 and the output is 0, whatever the group bit and the candidates carry.
- R7: When at most one pair enable is set, `cfg_err` is 0.
- R8: With `OUT_REG=1`, `sel_out` and `cfg_err` show the result for the inputs that were present at the previous rising clock edge. While `rst_n` is low, both are 0.
- R9: Candidates outside the selected one have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_hi | input | PAIRS*DATA_W | High-group candidates A, B, C, D, with candidate 0 in the lowest slice |
| cand_lo | input | PAIRS*DATA_W | Low-group candidates E, F, G, H, with candidate 0 in the lowest slice |
| sel_cfg | input | PAIRS+1 | Pair enables in bits [PAIRS-1:0] and the group bit (1 = high) in bit PAIRS |
| sel_out | output | DATA_W | Selected candidate, or 0 when the input is unused or the code is illegal |
| cfg_err | output | 1 | Set when more than one pair enable is active |

## Verification
With the default registered output, every result is due exactly one rising edge after its inputs are applied. The bench drives the inputs on the falling edge and, in the same step, pushes the expected output and error flag into a scoreboard queue. The monitor samples 2 ns after the next rising edge, pops one expected item and compares it with the outputs. Because the driver pushes one item per cycle and the monitor pops one per cycle, each comparison lines up with the vector applied in the previous cycle. The reset values are read directly while reset is held, before any vector is applied.

// File: rtl/isel_pkg.sv
package isel_pkg;

   typedef enum logic [1:0] {
      SEL_IDLE     = 2'd0,
      SEL_ONE      = 2'd1,
      SEL_CONFLICT = 2'd2
   } sel_status_e;

endpackage

// File: rtl/isel_enable_guard.sv
module isel_enable_guard
   import isel_pkg::*;
#(
   parameter int PAIRS = 4
) (
   input  logic [PAIRS-1:0] pair_en,
   output sel_status_e      status
);
   localparam int CNT_W = $clog2(PAIRS + 1);

   logic [CNT_W-1:0] active_cnt;

   always_comb begin
      active_cnt = '0;
      for (int k = 0; k < PAIRS; k++) begin
         active_cnt = active_cnt + CNT_W'(pair_en[k]);
      end
   end

   always_comb begin
      if (active_cnt == '0)      status = SEL_IDLE;
      else if (active_cnt == 1)  status = SEL_ONE;
      else                       status = SEL_CONFLICT;
   end

   // R7: a single-pair status must come from a truly one-hot enable field
   always_comb begin
      if (status == SEL_ONE) begin
         a_guard_onehot_r7: assert ($onehot(pair_en));
      end
   end

endmodule

// File: rtl/isel_pair_stage.sv
module isel_pair_stage #(
   parameter int PAIRS  = 4,
   parameter int DATA_W = 1
) (
   input  logic [PAIRS-1:0]        pair_en,
   input  logic [PAIRS*DATA_W-1:0] cand_hi,
   input  logic [PAIRS*DATA_W-1:0] cand_lo,
   output logic [DATA_W-1:0]       hi_bus,
   output logic [DATA_W-1:0]       lo_bus
);
   logic [PAIRS*DATA_W-1:0] gated_hi;
   logic [PAIRS*DATA_W-1:0] gated_lo;

   // First stage: each pair enable passes its two members onto shared buses
   for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign gated_hi[k*DATA_W +: DATA_W] = cand_hi[k*DATA_W +: DATA_W] & {DATA_W{pair_en[k]}};
      assign gated_lo[k*DATA_W +: DATA_W] = cand_lo[k*DATA_W +: DATA_W] & {DATA_W{pair_en[k]}};
   end

   always_comb begin
      hi_bus = '0;
      lo_bus = '0;
      for (int k = 0; k < PAIRS; k++) begin
         hi_bus = hi_bus | gated_hi[k*DATA_W +: DATA_W];
         lo_bus = lo_bus | gated_lo[k*DATA_W +: DATA_W];
      end
   end

   // R9: with no enable, neither bus may carry anything
   always_comb begin
      if (pair_en == '0) begin
         a_bus_quiet_r9: assert (hi_bus == '0 && lo_bus == '0);
      end
   end

endmodule

// File: rtl/isel_group_stage.sv
module isel_group_stage
   import isel_pkg::*;
#(
   parameter int DATA_W = 1
) (
   input  logic [DATA_W-1:0] hi_bus,
   input  logic [DATA_W-1:0] lo_bus,
   input  logic              grp_hi,
   input  sel_status_e       status,
   output logic [DATA_W-1:0] out_d,
   output logic              err_d
);
   logic [DATA_W-1:0] picked;

   // Second stage: one bit chooses which member of the pair reaches the cell
   assign picked = grp_hi ? hi_bus : lo_bus;

   always_comb begin
      unique case (status)
         SEL_ONE: begin
            out_d = picked;
            err_d = 1'b0;
         end
         SEL_CONFLICT: begin
            out_d = '0;
            err_d = 1'b1;
         end
         default: begin
            out_d = '0;
            err_d = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/isel_two_stage.sv
module isel_two_stage
   import isel_pkg::*;
#(
   parameter int PAIRS   = 4,
   parameter int DATA_W  = 1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PAIRS*DATA_W-1:0] cand_hi,
   input  logic [PAIRS*DATA_W-1:0] cand_lo,
   input  logic [PAIRS:0]          sel_cfg,
   output logic [DATA_W-1:0]       sel_out,
   output logic                    cfg_err
);
   localparam int GRP_BIT = PAIRS;

   if (PAIRS < 2) begin : g_bad_pairs
      $error("isel_two_stage: PAIRS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("isel_two_stage: DATA_W must be at least 1");
   end

   logic [PAIRS-1:0]  pair_en;
   logic              grp_hi;
   sel_status_e       status;
   logic [DATA_W-1:0] hi_bus;
   logic [DATA_W-1:0] lo_bus;
   logic [DATA_W-1:0] out_d;
   logic              err_d;

   assign pair_en = sel_cfg[PAIRS-1:0];
   assign grp_hi  = sel_cfg[GRP_BIT];

   isel_enable_guard #(.PAIRS(PAIRS)) u_guard (
      .pair_en (pair_en),
      .status  (status)
   );

   isel_pair_stage #(.PAIRS(PAIRS), .DATA_W(DATA_W)) u_pairs (
      .pair_en (pair_en),
      .cand_hi (cand_hi),
      .cand_lo (cand_lo),
      .hi_bus  (hi_bus),
      .lo_bus  (lo_bus)
   );

   isel_group_stage #(.DATA_W(DATA_W)) u_group (
      .hi_bus  (hi_bus),
      .lo_bus  (lo_bus),
      .grp_hi  (grp_hi),
      .status  (status),
      .out_d   (out_d),
      .err_d   (err_d)
   );

   if (OUT_REG) begin : g_reg
      logic primed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_out <= '0;
            cfg_err <= 1'b0;
            primed  <= 1'b0;
         end else begin
            sel_out <= out_d;
            cfg_err <= err_d;
            primed  <= 1'b1;
         end
      end

      p_err_zero_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_err |-> sel_out == '0);

      p_conflict_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $countones($past(sel_cfg[PAIRS-1:0])) > 1 |-> cfg_err);

      p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(sel_cfg[PAIRS-1:0]) == '0 |-> sel_out == '0 && !cfg_err);

      p_no_false_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $countones($past(sel_cfg[PAIRS-1:0])) <= 1 |-> !cfg_err);
   end else begin : g_comb
      assign sel_out = out_d;
      assign cfg_err = err_d;
   end

endmodule

// File: tb/isel_two_stage_bench.sv
module isel_two_stage_bench;
   localparam int N = 4;
   localparam int W = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N*W-1:0] cand_hi = '0;
   logic [N*W-1:0] cand_lo = '0;
   logic [N:0]     sel_cfg = '0;
   logic [W-1:0]   sel_out;
   logic           cfg_err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [W-1:0] q_out[$];
   logic         q_err[$];
   string        q_tag[$];

   always #10 clk = ~clk;

   isel_two_stage #(.PAIRS(N), .DATA_W(W), .OUT_REG(1'b1)) u_isel_two_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand_hi (cand_hi),
      .cand_lo (cand_lo),
      .sel_cfg (sel_cfg),
      .sel_out (sel_out),
      .cfg_err (cfg_err)
   );

   function automatic void model(input logic [N:0] c, input logic [N*W-1:0] h,
                                 input logic [N*W-1:0] l,
                                 output logic [W-1:0] o, output logic e);
      int cnt = 0;
      int idx = 0;
      for (int k = 0; k < N; k++) begin
         if (c[k]) begin
            cnt++;
            idx = k;
         end
      end
      if (cnt == 0) begin
         o = '0; e = 1'b0;
      end else if (cnt > 1) begin
         o = '0; e = 1'b1;
      end else begin
         o = c[N] ? h[idx*W +: W] : l[idx*W +: W];
         e = 1'b0;
      end
   endfunction

   task automatic drive(input logic [N:0] c, input logic [N*W-1:0] h,
                        input logic [N*W-1:0] l, input string tag);
      logic [W-1:0] o;
      logic e;
      @(negedge clk);
      sel_cfg = c;
      cand_hi = h;
      cand_lo = l;
      model(c, h, l, o, e);
      q_out.push_back(o);
      q_err.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic check(input string tag, input logic [W-1:0] ao, input logic ae,
                        input logic [W-1:0] eo, input logic ee);
      n_checks++;
      if (ao !== eo || ae !== ee) begin
         n_fail++;
         $display("FAIL %s: got out=%0h err=%0b, expected out=%0h err=%0b",
                  tag, ao, ae, eo, ee);
      end
   endtask

   // monitor: one result per rising edge, due one edge after its vector
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && q_out.size() > 0) begin
            check(q_tag.pop_front(), sel_out, cfg_err, q_out.pop_front(), q_err.pop_front());
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got cycle=%0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [N*W-1:0] h;
      logic [N*W-1:0] l;
      // R8: reset state
      repeat (3) @(negedge clk);
      cand_hi = '1; cand_lo = '1; sel_cfg = 5'b1_0001;
      @(negedge clk);
      check("R8 reset", sel_out, cfg_err, '0, 1'b0);
      rst_n = 1'b1;

      // R1: walk each pair with distinct per-slot values
      for (int k = 0; k < N; k++) begin
         drive({1'b1, 4'(1 << k)}, 8'b11_10_01_00, 8'b00_01_10_11, "R1 pair map hi");
         drive({1'b0, 4'(1 << k)}, 8'b11_10_01_00, 8'b00_01_10_11, "R1 pair map lo");
      end
      // R2, R3, R7: single enables with random data
      for (int r = 0; r < 12; r++) begin
         for (int k = 0; k < N; k++) begin
            h = 8'($urandom); l = 8'($urandom);
            drive({1'b1, 4'(1 << k)}, h, l, "R2 high group");
            h = 8'($urandom); l = 8'($urandom);
            drive({1'b0, 4'(1 << k)}, h, l, "R3 low group R7");
         end
      end
      // R4, R9: B passes alone; others toggle freely
      for (int r = 0; r < 10; r++) begin
         h = 8'($urandom); l = 8'($urandom);
         h[3:2] = 2'(r);
         drive(5'b1_0010, h, l, "R4 B only R9");
      end
      drive(5'b1_0010, 8'b00_10_00_00, 8'b11_11_11_11, "R9 others ignored");
      drive(5'b1_0010, 8'b11_10_11_11, 8'b00_00_00_00, "R9 others ignored");
      // R5: unused input
      for (int r = 0; r < 6; r++) begin
         drive({1'(r), 4'b0000}, 8'($urandom) | 8'h81, 8'($urandom), "R5 idle");
      end
      // R6: conflicting enables
      drive(5'b1_0011, '1, '1, "R6 conflict");
      drive(5'b0_1111, '1, '1, "R6 conflict");
      drive(5'b1_0101, 8'h5a, 8'ha5, "R6 conflict");
      drive(5'b0_1100, 8'hff, 8'h00, "R6 conflict");
      drive(5'b1_1000, 8'hc0, 8'h00, "R7 recover");
      // R8: back-to-back changes, result one edge later each
      drive(5'b0_0100, 8'h00, 8'h30, "R8 latency");
      drive(5'b0_0100, 8'h00, 8'h00, "R8 latency");
      drive(5'b1_0001, 8'h03, 8'h00, "R8 latency");
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      if (q_out.size() != 0) begin
         n_fail++;
         $display("FAIL R8: got %0d pending results, expected 0", q_out.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule